// File: doc/BRIEF.md
# Two-Width PWM Timer Channel

This block is one down-counting timer channel behind a small register port. Software sets a control word and two reload values. In timer use the channel counts down, and each time it reaches zero it counts as an expiry and raises a sticky interrupt flag. In waveform use the output pin flips at every expiry. One reload value sets how long the low phase lasts and the other sets how long the high phase lasts, so period and duty are programmed independently.

Each phase lasts its reload value plus one clock. The waveform always starts in the low phase. For these two reasons the output can never sit fully high or fully low while the channel runs. The expected software flow is to clear the enable bit, write the reload values, then set the enable bit again. Setting the enable bit loads the low-phase reload value into the counter.

The counter width is a parameter (default 32). The address width is also a parameter and must be at least 8.

Top module: `pwmt_channel`

## Requirements
- R1: After reset, all registers read as zero, `pwm_out` is 0 and `irq` is 0.
- R2: In waveform mode (control value 0xB: enable bit 0, reload-mode bit 1, waveform bit 3), the low phase lasts LO+1 clocks and the high phase lasts HI+1 clocks. Here LO is the value at offset 0x00 and HI is the value at offset 0xB0. The two phases alternate without end.
- R3: With the reload-mode bit set and the waveform bit clear, the counter reloads LO at each expiry and `pwm_out` stays low. The counter is read at offset 0x04.
- R4: With the reload-mode bit clear, an expiry reloads the counter with all ones and `pwm_out` never toggles, even if the waveform bit is set.
- R5: Every expiry sets a status flag, read as bit 0 at offset 0x10. Reading that offset does not clear the flag. `irq` equals the flag AND NOT the mask bit (control bit 2).
- R6: A read of offset 0x0C returns the status flag and clears it on that clock edge. An expiry on the same edge takes precedence.
- R7: Clearing the enable bit freezes the counter and forces `pwm_out` low. The reload and control registers keep their contents.
- R8: A write to the high-phase reload value while the channel runs takes effect at the next high-phase reload.
- R9: The registers sit at these offsets: low reload 0x00, counter 0x04, control 0x08 (bits 3:0), end-of-interrupt 0x0C, status 0x10, high reload 0xB0. Any other offset reads 0, and writes to it are ignored.
- R10: When the enable bit goes from 0 to 1, the counter loads LO and the output starts in the low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of 0x0C clears status) |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data, combinational from `addr` |
| pwm_out | output | 1 | Waveform output |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest case to reach from the ports is a reload-value write that lands while a phase is already counting. It must change only the next phase of that kind and leave the current one alone. The bench enables the channel and, on the very next clock, rewrites the high-phase value while the low phase is still running. It then measures the lengths of the following runs of the output level. Full-width free-running wraps take too many cycles to reach from the ports, so the bench builds the channel with an 8-bit counter. This makes the all-ones reload observable within a few hundred cycles, and the bench also sweeps every pairing of small low and high widths.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
    localparam logic [7:0] OFS_LD_LO = 8'h00;
    localparam logic [7:0] OFS_CUR   = 8'h04;
    localparam logic [7:0] OFS_CTRL  = 8'h08;
    localparam logic [7:0] OFS_EOI   = 8'h0C;
    localparam logic [7:0] OFS_STS   = 8'h10;
    localparam logic [7:0] OFS_LD_HI = 8'hB0;

    typedef struct packed {
        logic pwm;
        logic mask;
        logic user;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
    import pwmt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    input  logic              expire_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [CNT_W-1:0]  ld_lo_o,
    output logic [CNT_W-1:0]  ld_hi_o,
    output ctrl_t             ctrl_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] ld_lo;
        logic [CNT_W-1:0] ld_hi;
        ctrl_t            ctrl;
        logic             sts;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic hit_lo, hit_hi, hit_ctrl, hit_cur, hit_eoi, hit_sts;

    always_comb begin
        hit_lo   = (addr_i == ADDR_W'(OFS_LD_LO));
        hit_hi   = (addr_i == ADDR_W'(OFS_LD_HI));
        hit_ctrl = (addr_i == ADDR_W'(OFS_CTRL));
        hit_cur  = (addr_i == ADDR_W'(OFS_CUR));
        hit_eoi  = (addr_i == ADDR_W'(OFS_EOI));
        hit_sts  = (addr_i == ADDR_W'(OFS_STS));

        st_d = st_q;
        if (wr_en_i) begin
            if (hit_lo)   st_d.ld_lo = wdata_i;
            if (hit_hi)   st_d.ld_hi = wdata_i;
            if (hit_ctrl) st_d.ctrl  = ctrl_t'(wdata_i[3:0]);
        end
        if (rd_en_i && hit_eoi) st_d.sts = 1'b0;
        if (expire_i)           st_d.sts = 1'b1;

        rdata_o = '0;
        if (hit_lo)             rdata_o = st_q.ld_lo;
        if (hit_hi)             rdata_o = st_q.ld_hi;
        if (hit_cur)            rdata_o = cnt_i;
        if (hit_ctrl)           rdata_o = CNT_W'(st_q.ctrl);
        if (hit_eoi || hit_sts) rdata_o = CNT_W'(st_q.sts);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ld_lo_o = st_q.ld_lo;
    assign ld_hi_o = st_q.ld_hi;
    assign ctrl_o  = st_q.ctrl;
    assign irq_o   = st_q.sts & ~st_q.ctrl.mask;

    // R5: an expiry leaves the flag set on the following cycle
    p_expire_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> st_q.sts);
    // R5: the flag holds unless an end-of-interrupt read happens
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sts && !(rd_en_i && hit_eoi)) |=> st_q.sts);
    // R6: an end-of-interrupt read without a competing expiry clears the flag
    p_eoi_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && hit_eoi && !expire_i) |=> !st_q.sts);
endmodule

// File: rtl/pwmt_core.sv
module pwmt_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             user_i,
    input  logic             pwm_i,
    input  logic [CNT_W-1:0] ld_lo_i,
    input  logic [CNT_W-1:0] ld_hi_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o,
    output logic             out_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             out;
        logic             run;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (!en_i) begin
            st_d.run = 1'b0;
            st_d.out = 1'b0;
        end else if (!st_q.run) begin
            st_d.run = 1'b1;
            st_d.cnt = ld_lo_i;
            st_d.out = 1'b0;
        end else if (st_q.cnt == '0) begin
            expire_o = 1'b1;
            if (!user_i) begin
                st_d.cnt = '1;
            end else if (pwm_i) begin
                st_d.out = ~st_q.out;
                st_d.cnt = st_q.out ? ld_lo_i : ld_hi_i;
            end else begin
                st_d.cnt = ld_lo_i;
            end
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign out_o = st_q.out;

    // R10: a fresh start loads the low-phase value and begins low
    p_low_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.run) |-> (st_q.cnt == $past(ld_lo_i)) && !st_q.out);
    // R7: a disabled channel drives the output low
    p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !out_o);
    // R7: a disabled channel does not move its counter
    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> $stable(cnt_o));
    // R2: a running non-zero count steps down by one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && en_i && st_q.cnt != '0) |=> cnt_o == $past(cnt_o) - 1'b1);
    // R4: free-running mode never toggles the output
    p_free_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !user_i) |=> $stable(out_o));
endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
    import pwmt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              pwm_out,
    output logic              irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] ld_lo, ld_hi, cnt;
    logic             expire;

    pwmt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .rd_en_i  (rd_en),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .expire_i (expire),
        .cnt_i    (cnt),
        .ld_lo_o  (ld_lo),
        .ld_hi_o  (ld_hi),
        .ctrl_o   (ctrl),
        .irq_o    (irq)
    );

    pwmt_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (ctrl.en),
        .user_i   (ctrl.user),
        .pwm_i    (ctrl.pwm),
        .ld_lo_i  (ld_lo),
        .ld_hi_i  (ld_hi),
        .cnt_o    (cnt),
        .expire_o (expire),
        .out_o    (pwm_out)
    );

    // R5: a masked channel never raises its interrupt
    p_mask_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.mask |-> !irq);
endmodule

// File: tb/sim_pwmt_channel.sv
module sim_pwmt_channel;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [CNT_W-1:0]  wdata = '0;
    logic [CNT_W-1:0]  rdata;
    logic              pwm_out;
    logic              irq;

    int checks = 0;
    int errors = 0;

    pwmt_channel #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [CNT_W-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [CNT_W-1:0] v);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        rd_en = 1'b0;
    endtask

    task automatic eoi_rd(output logic [CNT_W-1:0] v);
        rd_en = 1'b1; addr = 8'h0C;
        #1 v = rdata;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Starts at the first sample after the loading edge.
    task automatic measure(input int lo, input int hi, input string req);
        int runs[3];
        int n = 0;
        int len = 1;
        logic prev;
        runs = '{0, 0, 0};
        prev = pwm_out;
        check({req, " R10 first phase low"}, int'(pwm_out), 0);
        for (int i = 1; i < 45; i++) begin
            @(negedge clk);
            if (pwm_out == prev) len++;
            else begin
                if (n < 3) runs[n] = len;
                n++; len = 1; prev = pwm_out;
            end
        end
        check({req, " low width"},   runs[0], lo + 1);
        check({req, " high width"},  runs[1], hi + 1);
        check({req, " second low"},  runs[2], lo + 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [CNT_W-1:0] v, v2;
        logic saw_high;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 pwm_out", int'(pwm_out), 0);
        check("R1 irq", int'(irq), 0);
        rd(8'h00, v); check("R1 low reload", int'(v), 0);
        rd(8'h08, v); check("R1 control", int'(v), 0);
        rd(8'h04, v); check("R1 counter", int'(v), 0);
        rd(8'hB0, v); check("R1 high reload", int'(v), 0);

        // R9 offsets and unmapped space
        wr(8'h00, 8'h5A); wr(8'hB0, 8'hA5); wr(8'h08, 8'h04);
        rd(8'h00, v); check("R9 low reload at 0x00", int'(v), 8'h5A);
        rd(8'hB0, v); check("R9 high reload at 0xB0", int'(v), 8'hA5);
        rd(8'h08, v); check("R9 control at 0x08", int'(v), 8'h04);
        wr(8'h14, 8'h33);
        rd(8'h14, v); check("R9 unmapped reads zero", int'(v), 0);
        rd(8'h00, v); check("R9 unmapped write ignored", int'(v), 8'h5A);

        // R2 / R10 sweep of small widths
        for (int lo = 0; lo < 6; lo++) begin
            for (int hi = 0; hi < 6; hi++) begin
                wr(8'h08, 8'h00);
                wr(8'h00, CNT_W'(lo));
                wr(8'hB0, CNT_W'(hi));
                wr(8'h08, 8'h0B);
                @(posedge clk); @(negedge clk);
                measure(lo, hi, "R2 sweep");
            end
        end

        // R8 high reload rewritten during the first low phase
        wr(8'h08, 8'h00);
        wr(8'h00, 8'd2); wr(8'hB0, 8'd2);
        wr(8'h08, 8'h0B);
        wr(8'hB0, 8'd6);
        measure(2, 6, "R8 live high rewrite");

        // R3 reload-mode timer without waveform, R5, R6
        wr(8'h08, 8'h00);
        eoi_rd(v);
        wr(8'h00, 8'd3);
        wr(8'h08, 8'h03);
        @(posedge clk); @(negedge clk);
        for (int j = 0; j < 10; j++) begin
            rd(8'h04, v);
            check("R3 counter sequence", int'(v), 3 - (j % 4));
            check("R3 output stays low", int'(pwm_out), 0);
            @(negedge clk);
        end
        rd(8'h10, v); check("R5 status set by expiry", int'(v), 1);
        check("R5 irq unmasked", int'(irq), 1);
        wr(8'h08, 8'h07);
        check("R5 irq masked", int'(irq), 0);
        rd(8'h10, v); check("R5 status read does not clear", int'(v), 1);
        wr(8'h08, 8'h04);
        eoi_rd(v); check("R6 eoi returns status", int'(v), 1);
        rd(8'h10, v); check("R6 eoi clears status", int'(v), 0);
        wr(8'h08, 8'h00);
        check("R6 irq low after clear", int'(irq), 0);

        // R7 disable mid-run, R10 re-enable
        wr(8'h00, 8'd5); wr(8'hB0, 8'd5);
        wr(8'h08, 8'h0B);
        @(posedge clk); @(negedge clk);
        wr(8'h08, 8'h08);
        rd(8'h04, v);
        repeat (5) @(negedge clk);
        rd(8'h04, v2);
        check("R7 counter frozen", int'(v2), int'(v));
        check("R7 output low", int'(pwm_out), 0);
        rd(8'h00, v); check("R7 low reload kept", int'(v), 5);
        rd(8'hB0, v); check("R7 high reload kept", int'(v), 5);
        rd(8'h08, v); check("R7 control kept", int'(v), 8'h08);
        wr(8'h08, 8'h0B);
        @(posedge clk); @(negedge clk);
        rd(8'h04, v); check("R10 counter reloaded on enable", int'(v), 5);
        measure(5, 5, "R10 re-enable");

        // R4 free-running with waveform bit set
        wr(8'h08, 8'h00);
        wr(8'h00, 8'd2);
        wr(8'h08, 8'h09);
        @(posedge clk); @(negedge clk);
        rd(8'h04, v); check("R4 start count", int'(v), 2);
        repeat (3) @(negedge clk);
        rd(8'h04, v); check("R4 reload all ones", int'(v), 8'hFF);
        @(negedge clk);
        rd(8'h04, v); check("R4 counts down from all ones", int'(v), 8'hFE);
        saw_high = 1'b0;
        for (int k = 0; k < 300; k++) begin
            if (pwm_out) saw_high = 1'b1;
            @(negedge clk);
        end
        check("R4 no toggle across wrap", int'(saw_high), 0);
        rd(8'h10, v); check("R4 expiry sets status", int'(v), 1);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule